// File: doc/BRIEF.md
# Single-Cycle 8-Bit Accumulator Processor

This block is a small 8-bit processor that runs a fixed program of up to sixteen one-byte instructions, one instruction per clock cycle. It holds three architectural registers. The data register (`r1`) and the count register (`rc`) both load from a shared external 8-bit input bus. The accumulator (`acc`) takes every ALU result. The ALU operand routing is fixed: the data register always drives operand A and the accumulator always drives operand B. Counted loops come from decrementing the count register and branching back while it is non-zero.

The program is a packed parameter, read combinationally at the program counter. The accumulator value is also presented as two hexadecimal seven-segment digits, one for each nibble. The block is used by choosing the program at instantiation and then feeding data on the input bus in the cycles where the program executes a load.

Top module: `acc8_core`

## Requirements
- R1: An active-low `rst_n` clears the program counter, `r1`, `rc` and `acc` to zero at once, without waiting for a clock edge.
- R2: Instruction word i of the `PROGRAM` parameter sits at bits [8i+7:8i]. Its upper nibble is the opcode and its lower nibble is the branch target. For any opcode other than 0xB and 0xF, the program counter advances by one modulo 16 on each clock edge.
- R3: Opcode 0x1 loads `r1` from `in_bus`, and opcode 0x2 loads `rc` from `in_bus`. Each load takes effect on the clock edge at which the instruction executes.
- R4: Opcode 0x3 lowers `rc` by one modulo 256, so a value of 0x00 becomes 0xFF.
- R5: Opcode 0x4 sets acc = r1 + acc, 0x5 sets acc = acc - r1, 0x6 sets acc = r1 AND acc, 0x7 sets acc = r1 OR acc, and 0x8 sets acc = r1 XOR acc. All results are kept modulo 256 and no carry is stored.
- R6: Opcode 0x9 copies `r1` into `acc`, and opcode 0xA clears `acc` to zero.
- R7: Opcode 0xB jumps to its target when `rc` is non-zero, and otherwise steps to the next address. It leaves all three registers unchanged.
- R8: Opcode 0xF holds the program counter and all three registers for as long as it is the current instruction.
- R9: Opcode 0x0 and the unassigned opcodes 0xC, 0xD and 0xE change only the program counter. A register that the current instruction does not write keeps its value, whatever is on `in_bus`.
- R10: `seg_hi_o` shows acc[7:4] and `seg_lo_o` shows acc[3:0] as active-high segments, with bit 0 = a through bit 6 = g. The patterns for digits 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_bus | input | 8 | Shared load data for the data and count registers |
| pc_o | output | 4 | Program counter |
| r1_o | output | 8 | Data register |
| rc_o | output | 8 | Count register |
| acc_o | output | 8 | Accumulator |
| seg_hi_o | output | 7 | Seven-segment pattern of the upper accumulator nibble |
| seg_lo_o | output | 7 | Seven-segment pattern of the lower accumulator nibble |

## Verification
The properties assume that `in_bus` carries a known value at every rising clock edge and that `rst_n` only changes away from the rising edge. They also take the program parameter as fixed for the whole run. The bench changes `in_bus` and releases reset only on the falling edge. It draws bus data from a seeded random source, with 0x00 and 0xFF injected often. It sets the first count value directly, so that the wrap-to-0xFF loop and the single-pass loop both run to the halt instruction. One reset is asserted in the middle of a clock phase, partway through a loop.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_NOP   = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LDR1  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_LDRC  = 4'h2;
  localparam logic [OPC_W-1:0] OPC_DECRC = 4'h3;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h4;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'h5;
  localparam logic [OPC_W-1:0] OPC_AND   = 4'h6;
  localparam logic [OPC_W-1:0] OPC_OR    = 4'h7;
  localparam logic [OPC_W-1:0] OPC_XOR   = 4'h8;
  localparam logic [OPC_W-1:0] OPC_MOV   = 4'h9;
  localparam logic [OPC_W-1:0] OPC_CLR   = 4'hA;
  localparam logic [OPC_W-1:0] OPC_BNZ   = 4'hB;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR,
    ALU_PASS_A,
    ALU_ZERO
  } alu_fn_e;

  typedef struct packed {
    logic    ld_r1;
    logic    ld_rc;
    logic    dec_rc;
    logic    acc_we;
    alu_fn_e alu_fn;
    logic    branch;
    logic    halt;
  } ctrl_t;

endpackage

// File: rtl/acc8_prog_rom.sv
module acc8_prog_rom #(
  parameter int ADDR_W = 4,
  parameter int INSTR_W = 8,
  parameter logic [(1<<ADDR_W)*INSTR_W-1:0] PROGRAM = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [INSTR_W-1:0] instr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [INSTR_W-1:0] words [DEPTH];

  // Unpack the parameter into a word array, one entry per address.
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign words[i] = PROGRAM[i*INSTR_W +: INSTR_W];
  end

  assign instr = words[addr];
endmodule

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl
);
  always_comb begin
    ctrl = '{ld_r1: 1'b0, ld_rc: 1'b0, dec_rc: 1'b0, acc_we: 1'b0,
             alu_fn: ALU_ZERO, branch: 1'b0, halt: 1'b0};
    case (opcode)
      OPC_LDR1:  ctrl.ld_r1  = 1'b1;
      OPC_LDRC:  ctrl.ld_rc  = 1'b1;
      OPC_DECRC: ctrl.dec_rc = 1'b1;
      OPC_ADD:   begin ctrl.acc_we = 1'b1; ctrl.alu_fn = ALU_ADD;    end
      OPC_SUB:   begin ctrl.acc_we = 1'b1; ctrl.alu_fn = ALU_SUB;    end
      OPC_AND:   begin ctrl.acc_we = 1'b1; ctrl.alu_fn = ALU_AND;    end
      OPC_OR:    begin ctrl.acc_we = 1'b1; ctrl.alu_fn = ALU_OR;     end
      OPC_XOR:   begin ctrl.acc_we = 1'b1; ctrl.alu_fn = ALU_XOR;    end
      OPC_MOV:   begin ctrl.acc_we = 1'b1; ctrl.alu_fn = ALU_PASS_A; end
      OPC_CLR:   begin ctrl.acc_we = 1'b1; ctrl.alu_fn = ALU_ZERO;   end
      OPC_BNZ:   ctrl.branch = 1'b1;
      OPC_HALT:  ctrl.halt   = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  alu_fn_e           fn,
  output logic [DATA_W-1:0] res
);
  // Operand A is the data register and operand B is the accumulator.
  // Subtraction is B minus A.
  always_comb begin
    case (fn)
      ALU_ADD:    res = opb + opa;
      ALU_SUB:    res = opb - opa;
      ALU_AND:    res = opb & opa;
      ALU_OR:     res = opb | opa;
      ALU_XOR:    res = opb ^ opa;
      ALU_PASS_A: res = opa;
      default:    res = '0;
    endcase
  end
endmodule

// File: rtl/acc8_hex7.sv
module acc8_hex7 (
  input  logic [3:0] nib,
  output logic [6:0] seg
);
  // Active-high segments, bit 0 = a through bit 6 = g.
  always_comb begin
    case (nib)
      4'h0: seg = 7'h3F;
      4'h1: seg = 7'h06;
      4'h2: seg = 7'h5B;
      4'h3: seg = 7'h4F;
      4'h4: seg = 7'h66;
      4'h5: seg = 7'h6D;
      4'h6: seg = 7'h7D;
      4'h7: seg = 7'h07;
      4'h8: seg = 7'h7F;
      4'h9: seg = 7'h6F;
      4'hA: seg = 7'h77;
      4'hB: seg = 7'h7C;
      4'hC: seg = 7'h39;
      4'hD: seg = 7'h5E;
      4'hE: seg = 7'h79;
      default: seg = 7'h71;
    endcase
  end
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [(1<<ADDR_W)*(OPC_W+ADDR_W)-1:0] PROGRAM = {
    8'hE0, 8'hF0, 8'h10, 8'hC5, 8'hA0, 8'hB3, 8'h30, 8'h60,
    8'h70, 8'h80, 8'h50, 8'h40, 8'h10, 8'h90, 8'h10, 8'h20}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_bus,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] r1_o,
  output logic [DATA_W-1:0] rc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [6:0]        seg_hi_o,
  output logic [6:0]        seg_lo_o
);
  localparam int INSTR_W  = OPC_W + ADDR_W;
  localparam int N_DIGITS = DATA_W / 4;

  logic [ADDR_W-1:0]  pc_q, pc_nxt;
  logic [DATA_W-1:0]  r1_q, rc_q, acc_q, rc_nxt, alu_res;
  logic [INSTR_W-1:0] cur_instr;
  logic [OPC_W-1:0]   cur_opc;
  logic [ADDR_W-1:0]  cur_tgt;
  logic               pc_en, r1_en, rc_en, acc_en;
  ctrl_t              ctrl;
  logic [6:0]         digit_seg [N_DIGITS];

  acc8_prog_rom #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .PROGRAM(PROGRAM)) rom_i (
    .addr (pc_q),
    .instr(cur_instr)
  );

  assign cur_opc = cur_instr[INSTR_W-1 -: OPC_W];
  assign cur_tgt = cur_instr[ADDR_W-1:0];

  acc8_decode dec_i (
    .opcode(cur_opc),
    .ctrl  (ctrl)
  );

  acc8_alu #(.DATA_W(DATA_W)) alu_i (
    .opa(r1_q),
    .opb(acc_q),
    .fn (ctrl.alu_fn),
    .res(alu_res)
  );

  // Next-state logic and clock enables.
  always_comb begin
    pc_en  = !ctrl.halt;
    r1_en  = ctrl.ld_r1;
    rc_en  = ctrl.ld_rc | ctrl.dec_rc;
    acc_en = ctrl.acc_we;
    if (ctrl.branch && (rc_q != '0)) pc_nxt = cur_tgt;
    else                             pc_nxt = pc_q + ADDR_W'(1);
    if (ctrl.ld_rc) rc_nxt = in_bus;
    else            rc_nxt = rc_q - DATA_W'(1);
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      r1_q  <= '0;
      rc_q  <= '0;
      acc_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_nxt;
      if (r1_en)  r1_q  <= in_bus;
      if (rc_en)  rc_q  <= rc_nxt;
      if (acc_en) acc_q <= alu_res;
    end
  end

  // One display decoder per accumulator nibble.
  for (genvar d = 0; d < N_DIGITS; d++) begin : g_digit
    acc8_hex7 hex_i (
      .nib(acc_q[4*d +: 4]),
      .seg(digit_seg[d])
    );
  end

  assign seg_lo_o = digit_seg[0];
  assign seg_hi_o = digit_seg[N_DIGITS-1];
  assign pc_o     = pc_q;
  assign r1_o     = r1_q;
  assign rc_o     = rc_q;
  assign acc_o    = acc_q;
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [DATA_W-1:0]         in_bus,
  input logic [ADDR_W-1:0]         pc_o,
  input logic [DATA_W-1:0]         r1_o,
  input logic [DATA_W-1:0]         rc_o,
  input logic [DATA_W-1:0]         acc_o,
  input logic [OPC_W+ADDR_W-1:0]   instr
);
  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] tgt;
  assign opc = instr[OPC_W+ADDR_W-1 -: OPC_W];
  assign tgt = instr[ADDR_W-1:0];

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (pc_o == '0 && r1_o == '0 && rc_o == '0 && acc_o == '0);
    end
  end

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (opc != OPC_BNZ && opc != OPC_HALT) |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

  assert_load_r1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_LDR1) |=> r1_o == $past(in_bus));

  assert_load_rc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_LDRC) |=> rc_o == $past(in_bus));

  assert_dec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_DECRC) |=> rc_o == DATA_W'($past(rc_o) - 1'b1));

  assert_add_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_ADD) |=> acc_o == DATA_W'($past(acc_o) + $past(r1_o)));

  assert_sub_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_SUB) |=> acc_o == DATA_W'($past(acc_o) - $past(r1_o)));

  assert_mov_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_MOV) |=> acc_o == $past(r1_o));

  assert_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_CLR) |=> acc_o == '0);

  assert_bnz_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BNZ && rc_o != '0) |=> pc_o == $past(tgt));

  assert_bnz_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BNZ && rc_o == '0) |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

  assert_bnz_regs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BNZ) |=> ($stable(r1_o) && $stable(rc_o) && $stable(acc_o)));

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_HALT) |=> ($stable(pc_o) && $stable(r1_o) && $stable(rc_o) && $stable(acc_o)));

  assert_nop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_NOP || opc == 4'hC || opc == 4'hD || opc == 4'hE)
    |=> ($stable(r1_o) && $stable(rc_o) && $stable(acc_o)));
endmodule

bind acc8_core acc8_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .in_bus(in_bus),
  .pc_o  (pc_o),
  .r1_o  (r1_o),
  .rc_o  (rc_o),
  .acc_o (acc_o),
  .instr (cur_instr)
);

// File: tb/acc8_core_tb_top.sv
module acc8_core_tb_top;
  localparam logic [127:0] PROG = {
    8'hE0, 8'hF0, 8'h10, 8'hC5, 8'hA0, 8'hB3, 8'h30, 8'h60,
    8'h70, 8'h80, 8'h50, 8'h40, 8'h10, 8'h90, 8'h10, 8'h20};

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [7:0] in_bus = 8'h00;
  logic [3:0] pc_o;
  logic [7:0] r1_o, rc_o, acc_o;
  logic [6:0] seg_hi_o, seg_lo_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_pc;
  logic [7:0] m_r1, m_rc, m_ac;

  always #4 clk = ~clk;

  acc8_core #(.DATA_W(8), .ADDR_W(4), .PROGRAM(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_bus(in_bus), .pc_o(pc_o), .r1_o(r1_o),
    .rc_o(rc_o), .acc_o(acc_o), .seg_hi_o(seg_hi_o), .seg_lo_o(seg_lo_o)
  );

  function automatic logic [6:0] seg_of(input logic [3:0] n);
    case (n)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic string reg_tag(input logic [3:0] op);
    case (op)
      4'h1, 4'h2: return "R3";
      4'h3:       return "R4";
      4'h4, 4'h5, 4'h6, 4'h7, 4'h8: return "R5";
      4'h9, 4'hA: return "R6";
      4'hB:       return "R7";
      4'hF:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  function automatic string pc_tag(input logic [3:0] op);
    if (op == 4'hB) return "R7";
    if (op == 4'hF) return "R8";
    return "R2";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string ptag, input string rtag);
    check(ptag, "pc", pc_o, m_pc);
    check(rtag, "r1", r1_o, m_r1);
    check(rtag, "rc", rc_o, m_rc);
    check(rtag, "acc", acc_o, m_ac);
    check("R10", "seg_hi", seg_hi_o, seg_of(m_ac[7:4]));
    check("R10", "seg_lo", seg_lo_o, seg_of(m_ac[3:0]));
  endtask

  // Reference step taken straight from the instruction set requirements.
  task automatic model_step(input logic [7:0] bus);
    logic [3:0] op;
    logic [3:0] tg;
    op = PROG[m_pc*8+4 +: 4];
    tg = PROG[m_pc*8 +: 4];
    case (op)
      4'h1: m_r1 = bus;
      4'h2: m_rc = bus;
      4'h3: m_rc = m_rc - 8'd1;
      4'h4: m_ac = m_r1 + m_ac;
      4'h5: m_ac = m_ac - m_r1;
      4'h6: m_ac = m_ac & m_r1;
      4'h7: m_ac = m_ac | m_r1;
      4'h8: m_ac = m_ac ^ m_r1;
      4'h9: m_ac = m_r1;
      4'hA: m_ac = 8'h00;
      default: ;
    endcase
    if (op == 4'hF)                    m_pc = m_pc;
    else if (op == 4'hB && m_rc != 0)  m_pc = tg;
    else                               m_pc = m_pc + 4'd1;
  endtask

  // Reset asserted mid-phase to show the clear is asynchronous (R1).
  task automatic do_reset();
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    m_pc = 0; m_r1 = 0; m_rc = 0; m_ac = 0;
    check_all("R1", "R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_episode(input logic [7:0] rc_seed, input int max_cyc, input int cut_at);
    int halted = 0;
    do_reset();
    for (int c = 0; c < max_cyc; c++) begin
      logic [7:0] bus;
      logic [3:0] op;
      int r;
      if (cut_at > 0 && c == cut_at) return;
      r = $urandom_range(0, 7);
      bus = (r == 0) ? 8'hFF : (r == 1) ? 8'h00 : 8'($urandom);
      if (m_pc == 0) bus = rc_seed;
      op = PROG[m_pc*8+4 +: 4];
      in_bus = bus;
      model_step(bus);
      @(negedge clk);
      check_all(pc_tag(op), reg_tag(op));
      if (op == 4'hF) halted++;
      if (halted >= 3) return;
    end
  endtask

  initial begin
    void'($urandom(32'h1A2B3C));
    run_episode(8'h01, 2500, 0);   // single pass through the loop
    run_episode(8'h00, 2500, 0);   // decrement from zero wraps to 0xFF
    run_episode(8'h02, 2500, 0);
    run_episode(8'h05, 2500, 30);  // reset cut in mid-loop
    run_episode(8'h03, 2500, 0);
    for (int k = 0; k < 4; k++) run_episode(8'($urandom_range(1, 40)), 2500, 0);
    run_episode(8'hFF, 2500, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule